// File: doc/BRIEF.md
# Host-to-Controller Mailbox Port

This block sits between a host processor's byte-wide bus and the core of an embedded peripheral controller. It holds one shared 8-bit data latch and a 4-bit status word. The host writes a byte, and the core reads it. The core writes a byte, and the host reads it. Two flags tell each side whether the latch holds something for it. One more flag records whether the host's last write was a command or data, and a spare flag is under the core's control.

The host bus is asynchronous to the block clock. Chip select, read strobe and write strobe are active low. The host-side strobe conditions pass through a synchronizer chain, and the block acts on the edges of the synchronized versions. A write is taken on the leading edge, while the host still drives the data lines. The side effect of a data read is applied on the trailing edge. The data lines are driven combinationally for as long as chip select and read strobe are both low.

Top module: `host_slave_port`

## Requirements
- R1: While the synchronous active-low reset is low on a clock edge, all four status flags are cleared. After reset the data latch reads 0x00.
- R2: A host write (CS and WR low) stores the byte on the data lines into the latch and sets the host-full flag. It also copies A0 into the command flag, so A0=1 marks a command and A0=0 marks data.
- R3: A host read with A0=1 drives the status byte {4'b0000, command flag, spare flag, host-full, core-full}, with bit 0 holding core-full and bit 3 holding the command flag. A status read changes no flag.
- R4: A host read with A0=0 drives the latch contents. When the read ends, the core-full flag clears.
- R5: A core write pulse loads the core's byte into the latch and sets core-full on the same clock edge.
- R6: The latch is always visible on the core read-data output. A core read pulse clears host-full on the next edge.
- R7: The core's spare-flag command takes a 2-bit code: 00 holds, 01 clears, 10 sets, 11 complements. It acts on the next edge.
- R8: Strobes given while CS is high have no effect on the latch or the flags.
- R9: If a set and a clear of the same flag fall on the same edge, the set wins. If a host write and a core write fall on the same edge, the host byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host register select: 0 data, 1 status/command |
| host_data | inout | 8 | Host data bus |
| core_out_wr | input | 1 | Core write pulse into the latch |
| core_out_data | input | 8 | Byte written by the core |
| core_in_rd | input | 1 | Core read pulse (clears host-full) |
| core_in_data | output | 8 | Latch contents seen by the core |
| core_f0_op | input | 2 | Spare-flag command: 00 hold, 01 clear, 10 set, 11 complement |
| ibf | output | 1 | Host-full flag (host byte waiting for the core) |
| obf | output | 1 | Core-full flag (core byte waiting for the host) |
| f0 | output | 1 | Spare flag |
| f1 | output | 1 | Command flag |

## Verification
On every cycle the assertions check the flag rules. A synchronized host write must leave host-full set and the command flag equal to A0. A core write must leave core-full set. A core read or a finished data read must clear its flag unless a set lands on the same edge. Host-full may rise only after a host write, and the upper status bits must read zero. The bench scenarios are the only way to show what the host actually sees. That covers the byte that crosses the latch in each direction, the decoding of status versus data, and the fact that strobes with chip select high are ignored. It also covers the outcome when a host edge and a core pulse land on the same clock, which the bench arranges by counting synchronizer stages.

// File: rtl/hsp_pkg.sv
// Package for the host mailbox port: spare-flag command codes and
// bit positions inside the host-visible status byte.
package hsp_pkg;

    localparam int DATA_W   = 8;
    localparam int STAT_W   = 4;

    // Status byte bit positions, read by host firmware, so fixed.
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_F0    = 2;
    localparam int ST_F1    = 3;

    typedef enum logic [1:0] {
        F0_HOLD   = 2'b00,
        F0_CLEAR  = 2'b01,
        F0_SET    = 2'b10,
        F0_TOGGLE = 2'b11
    } f0_op_e;

endpackage

// File: rtl/hsp_sync.sv
// Multi-bit synchronizer chain for asynchronous strobe conditions.
// Assumes each bit is a level that stays stable for several clocks;
// the bits are not treated as a coherent bus.
module hsp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hsp_edge.sv
// One-clock pulse on a chosen edge of a synchronized level.
// RISING=1 pulses when the level goes high, RISING=0 when it goes low.
// Assumes the input is already synchronous to clk.
module hsp_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic prev;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = level & ~prev;
        end else begin : g_fall
            assign pulse = ~level & prev;
        end
    endgenerate
endmodule

// File: rtl/hsp_latch.sv
// Shared data latch written by either side. A host write and a core
// write on the same edge resolve in favour of the host byte.
module hsp_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_byte,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_byte,
    output logic [DATA_W-1:0] q
);
    // Purpose: load the latch with host priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (host_wr) q <= host_byte;
        else if (core_wr) q <= core_byte;
    end
endmodule

// File: rtl/hsp_flags.sv
// Handshake flags: host-full, core-full, spare and command.
// A set and a clear on the same edge leave the flag set.
module hsp_flags
    import hsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_a0,
    input  logic       host_rd_done,
    input  logic       core_wr,
    input  logic       core_rd,
    input  logic [1:0] f0_op,
    output logic       ibf,
    output logic       obf,
    output logic       f0,
    output logic       f1
);
    f0_op_e op;
    assign op = f0_op_e'(f0_op);

    // Purpose: host-full sets on host write, clears on core read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ibf <= 1'b0;
        else if (host_wr) ibf <= 1'b1;
        else if (core_rd) ibf <= 1'b0;
    end

    // Purpose: core-full sets on core write, clears after host data read.
    always_ff @(posedge clk) begin
        if (!rst_n)            obf <= 1'b0;
        else if (core_wr)      obf <= 1'b1;
        else if (host_rd_done) obf <= 1'b0;
    end

    // Purpose: command flag follows A0 of each host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       f1 <= 1'b0;
        else if (host_wr) f1 <= host_a0;
    end

    // Purpose: spare flag under core command.
    always_ff @(posedge clk) begin
        if (!rst_n) f0 <= 1'b0;
        else begin
            unique case (op)
                F0_CLEAR:  f0 <= 1'b0;
                F0_SET:    f0 <= 1'b1;
                F0_TOGGLE: f0 <= ~f0;
                default:   f0 <= f0;
            endcase
        end
    end
endmodule

// File: rtl/host_slave_port.sv
// Top of the host mailbox port. Host strobe conditions are qualified
// by chip select, synchronized, and edge-detected. Writes act on the
// leading edge while the host still drives data and A0. Data reads
// clear core-full on the trailing edge. The bus is driven
// combinationally while CS and RD are low.
module host_slave_port
    import hsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    inout  wire  [DATA_W-1:0] host_data,
    input  logic              core_out_wr,
    input  logic [DATA_W-1:0] core_out_data,
    input  logic              core_in_rd,
    output logic [DATA_W-1:0] core_in_data,
    input  logic [1:0]        core_f0_op,
    output logic              ibf,
    output logic              obf,
    output logic              f0,
    output logic              f1
);
    localparam int REQ_W = 2;
    localparam int REQ_WR = 0;
    localparam int REQ_RD = 1;

    logic [REQ_W-1:0]  req_raw;
    logic [REQ_W-1:0]  req_sync;
    logic              host_wr_pulse;
    logic              host_rd_done;
    logic [DATA_W-1:0] latch_q;
    logic [STAT_W-1:0] status;
    logic              bus_oe;
    logic [DATA_W-1:0] bus_q;

    // Chip-select qualified strobe conditions; the read one covers data reads only.
    assign req_raw[REQ_WR] = ~host_cs_n & ~host_wr_n;
    assign req_raw[REQ_RD] = ~host_cs_n & ~host_rd_n & ~host_a0;

    hsp_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_raw),
        .sync_out (req_sync)
    );

    hsp_edge #(.RISING(1'b1)) u_wr_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (req_sync[REQ_WR]),
        .pulse (host_wr_pulse)
    );

    hsp_edge #(.RISING(1'b0)) u_rd_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (req_sync[REQ_RD]),
        .pulse (host_rd_done)
    );

    hsp_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr_pulse),
        .host_byte (host_data),
        .core_wr   (core_out_wr),
        .core_byte (core_out_data),
        .q         (latch_q)
    );

    hsp_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr_pulse),
        .host_a0      (host_a0),
        .host_rd_done (host_rd_done),
        .core_wr      (core_out_wr),
        .core_rd      (core_in_rd),
        .f0_op        (core_f0_op),
        .ibf          (ibf),
        .obf          (obf),
        .f0           (f0),
        .f1           (f1)
    );

    // Purpose: assemble the status nibble at its fixed bit positions.
    always_comb begin
        status         = '0;
        status[ST_OBF] = obf;
        status[ST_IBF] = ibf;
        status[ST_F0]  = f0;
        status[ST_F1]  = f1;
    end

    assign bus_oe       = ~host_cs_n & ~host_rd_n;
    assign bus_q        = host_a0 ? {{(DATA_W-STAT_W){1'b0}}, status} : latch_q;
    assign host_data    = bus_oe ? bus_q : {DATA_W{1'bz}};
    assign core_in_data = latch_q;
endmodule

// File: rtl/hsp_checker.sv
// Property checker for host_slave_port, attached by bind.
module hsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs_n,
    input logic       host_rd_n,
    input logic       host_a0,
    input logic [7:0] host_data,
    input logic       host_wr_pulse,
    input logic       host_rd_done,
    input logic       core_out_wr,
    input logic       core_in_rd,
    input logic [1:0] core_f0_op,
    input logic       ibf,
    input logic       obf,
    input logic       f0,
    input logic       f1
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!ibf && !obf && !f0 && !f1)); // R1

    AST_HOST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_pulse |=> ibf); // R2

    AST_HOST_WR_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_pulse |=> (f1 == $past(host_a0))); // R2

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && !host_rd_n && host_a0) |-> (host_data[7:4] == 4'h0)); // R3

    AST_RD_DONE_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_done && !core_out_wr) |=> !obf); // R4

    AST_CORE_WR_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_wr |=> obf); // R5

    AST_CORE_RD_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        (core_in_rd && !host_wr_pulse) |=> !ibf); // R6

    AST_F0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (core_f0_op == 2'b10) |=> f0); // R7

    AST_F0_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_f0_op == 2'b11) |=> (f0 != $past(f0))); // R7

    AST_IBF_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(host_wr_pulse)); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_pulse && core_in_rd) |=> ibf); // R9
endmodule

bind host_slave_port hsp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_cs_n     (host_cs_n),
    .host_rd_n     (host_rd_n),
    .host_a0       (host_a0),
    .host_data     (host_data),
    .host_wr_pulse (host_wr_pulse),
    .host_rd_done  (host_rd_done),
    .core_out_wr   (core_out_wr),
    .core_in_rd    (core_in_rd),
    .core_f0_op    (core_f0_op),
    .ibf           (ibf),
    .obf           (obf),
    .f0            (f0),
    .f1            (f1)
);

// File: tb/sim_host_slave_port.sv
module sim_host_slave_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic tb_oe = 1'b0;
    logic [7:0] tb_drv = 8'h00;
    wire  [7:0] host_data;
    logic core_out_wr = 1'b0, core_in_rd = 1'b0;
    logic [7:0] core_out_data = 8'h00;
    logic [7:0] core_in_data;
    logic [1:0] f0_op = 2'b00;
    logic ibf, obf, f0, f1;

    int checks = 0, errors = 0;
    logic [7:0] m_latch = 8'h00;
    logic m_ibf = 0, m_obf = 0, m_f0 = 0, m_f1 = 0;

    assign host_data = tb_oe ? tb_drv : 8'hzz;

    always #5 clk = ~clk;

    host_slave_port u0 (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n),
        .host_wr_n(wr_n), .host_a0(a0), .host_data(host_data),
        .core_out_wr(core_out_wr), .core_out_data(core_out_data),
        .core_in_rd(core_in_rd), .core_in_data(core_in_data),
        .core_f0_op(f0_op), .ibf(ibf), .obf(obf), .f0(f0), .f1(f1)
    );

    function automatic logic [7:0] exp_status();
        return {4'b0000, m_f1, m_f0, m_ibf, m_obf};
    endfunction

    function automatic logic exp_f0(input logic [1:0] op, input logic cur);
        case (op)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(req, {f1, f0, ibf, obf}, {m_f1, m_f0, m_ibf, m_obf});
        check(req, core_in_data, m_latch);
    endtask

    // Host write; optional core pulse placed on the synchronized action edge.
    task automatic host_write(input logic sel, input logic [7:0] d,
                              input logic with_core_rd, input logic with_core_wr,
                              input logic [7:0] cd);
        @(negedge clk);
        a0 = sel; tb_drv = d; tb_oe = 1; cs_n = 0; wr_n = 0;
        @(negedge clk);
        @(negedge clk);
        core_in_rd = with_core_rd; core_out_wr = with_core_wr; core_out_data = cd;
        @(negedge clk);
        core_in_rd = 0; core_out_wr = 0;
        @(negedge clk);
        wr_n = 1; cs_n = 1; tb_oe = 0;
        repeat (4) @(negedge clk);
        m_latch = d; m_ibf = 1; m_f1 = sel;
        if (with_core_wr) m_obf = 1;
    endtask

    // Host read; optional core write on the trailing action edge.
    task automatic host_read(input logic sel, output logic [7:0] v,
                             input logic with_core_wr, input logic [7:0] cd);
        @(negedge clk);
        a0 = sel; cs_n = 0; rd_n = 0;
        repeat (4) @(negedge clk);
        v = host_data;
        rd_n = 1; cs_n = 1;
        @(negedge clk);
        @(negedge clk);
        core_out_wr = with_core_wr; core_out_data = cd;
        @(negedge clk);
        core_out_wr = 0;
        repeat (2) @(negedge clk);
        if (with_core_wr) begin m_obf = 1; m_latch = cd; end
        else if (!sel) m_obf = 0;
    endtask

    task automatic core_write(input logic [7:0] d);
        @(negedge clk);
        core_out_wr = 1; core_out_data = d;
        @(negedge clk);
        core_out_wr = 0;
        m_latch = d; m_obf = 1;
    endtask

    task automatic core_read(output logic [7:0] v);
        @(negedge clk);
        core_in_rd = 1; v = core_in_data;
        @(negedge clk);
        core_in_rd = 0;
        m_ibf = 0;
    endtask

    task automatic f0_cmd(input logic [1:0] op);
        @(negedge clk);
        f0_op = op;
        @(negedge clk);
        f0_op = 2'b00;
        m_f0 = exp_f0(op, m_f0);
    endtask

    // Strobes with chip select high: must leave everything unchanged.
    task automatic deselected_strobes(input logic [7:0] d);
        @(negedge clk);
        cs_n = 1; a0 = d[0]; tb_drv = d; tb_oe = 1; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1; tb_oe = 0; rd_n = 0; a0 = 0;
        repeat (4) @(negedge clk);
        rd_n = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(100000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_flags("R1 reset");
        host_read(1'b1, v, 1'b0, 8'h00);
        check("R1 reset status", v, 8'h00);

        // Directed: host data write then core read
        host_write(1'b0, 8'hA5, 1'b0, 1'b0, 8'h00);
        check_flags("R2 data write");
        host_read(1'b1, v, 1'b0, 8'h00);
        check("R3 status after write", v, exp_status());
        core_read(v);
        check("R6 core sees byte", v, 8'hA5);
        @(negedge clk);
        check_flags("R6 ibf cleared");

        // Command write sets command flag
        host_write(1'b1, 8'h3C, 1'b0, 1'b0, 8'h00);
        check_flags("R2 command write");

        // Core write then host data read
        core_write(8'h5A);
        check_flags("R5 core write");
        host_read(1'b0, v, 1'b0, 8'h00);
        check("R4 host data read", v, 8'h5A);
        check_flags("R4 obf cleared");

        // Spare flag codes
        f0_cmd(2'b10); check_flags("R7 set");
        f0_cmd(2'b00); check_flags("R7 hold");
        f0_cmd(2'b11); check_flags("R7 toggle");
        f0_cmd(2'b11); check_flags("R7 toggle back");
        f0_cmd(2'b01); check_flags("R7 clear");

        // Deselected strobes ignored
        deselected_strobes(8'hEE);
        check_flags("R8 cs high ignored");

        // Coincident: host write and core read on same edge -> ibf set
        core_read(v);
        host_write(1'b0, 8'h77, 1'b1, 1'b0, 8'h00);
        check_flags("R9 ibf set wins");
        // Coincident host write and core write -> host byte in latch
        host_write(1'b0, 8'h12, 1'b0, 1'b1, 8'hF0);
        check_flags("R9 host byte wins");
        // Coincident host read done and core write -> obf set
        host_read(1'b0, v, 1'b1, 8'h9C);
        check("R4 read before coincident", v, 8'h12);
        check_flags("R9 obf set wins");

        // Random mix
        for (int i = 0; i < 200; i++) begin
            int kind = $urandom_range(0, 5);
            logic [7:0] d = 8'($urandom);
            case (kind)
                0: begin host_write(d[0], d, 1'b0, 1'b0, 8'h00); check_flags("R2 random write"); end
                1: begin
                    logic [7:0] e = m_latch;
                    host_read(1'b0, v, 1'b0, 8'h00);
                    check("R4 random data read", v, e);
                end
                2: begin
                    logic [7:0] e = exp_status();
                    host_read(1'b1, v, 1'b0, 8'h00);
                    check("R3 random status", v, e);
                end
                3: begin core_write(d); check_flags("R5 random core write"); end
                4: begin core_read(v); @(negedge clk); check_flags("R6 random core read"); end
                default: begin f0_cmd(d[1:0]); check_flags("R7 random f0"); end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule